// File: doc/BRIEF.md
# Configuration Completion Receiver

This block waits for the completion of a single configuration request that has already been sent. The completion arrives as a stream of 64-bit beats. Each beat can carry a start-of-packet flag, an end-of-packet flag, or neither. The receiver takes the completion status from the start beat and makes its decision on the end beat. For a read, it returns the 32-bit payload shifted down to the byte lane and size that were asked for.

The beat interface is polled. A beat is looked at only in a cycle where the poll tick is high, and each such cycle counts as one poll attempt. If no end beat arrives within a parameterised number of attempts (500 by default), the access ends as not-found. Software-visible issue of requests, tag matching and split completions are handled elsewhere.

Top module: `cfg_cpl_rx`

## Requirements
- R1: After reset, `done`, `err` and `rd_data` are all zero and the receiver is idle.
- R2: While idle, beats and poll ticks have no effect: `done` stays low and `err` and `rd_data` keep their values.
- R3: `start` is accepted only while idle, and it latches `acc_size` and `acc_offset`. A `start` that arrives during an access is ignored and does not change the latched size or offset.
- R4: A poll attempt is a busy cycle with `poll_tick` high. In a busy cycle with `poll_tick` low, the beat and its flags are ignored.
- R5: On a start-flagged beat, the completion status is taken from `rx_beat[47:45]`, which is bits 15:13 of the upper dword. Later beats without a start flag do not change the status.
- R6: On an end-flagged beat, a non-zero status completes the access with `err`=1 and `rd_data`=0. A zero status completes it with `err`=0 and the aligned payload.
- R7: At `start` the status is preset to a non-zero value, so a packet with an end flag and no earlier start flag reports an error. A beat that carries both flags is judged on its own status field.
- R8: The read payload is `rx_beat[31:0]` (the lower dword) of the end-flagged beat. With `acc_size` 2'b10 or 2'b11 (full dword), it is returned unshifted.
- R9: With `acc_size` 2'b00 (one byte), `rd_data` = (payload >> 8*`acc_offset`) & 0xFF.
- R10: With `acc_size` 2'b01 (two bytes), `rd_data` = (payload >> 16*`acc_offset[1]`) & 0xFFFF.
- R11: If the attempt numbered MAX_POLLS carries no end flag, the access completes with `err`=1 and `rd_data`=0. An end flag on that same attempt is honoured as a normal completion.
- R12: `done` is high for exactly one cycle, in the cycle right after the clock edge that sampled the deciding attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin waiting for a completion |
| acc_size | input | 2 | Access size: 00 byte, 01 two bytes, 10/11 dword |
| acc_offset | input | 2 | Byte offset of the access within the dword |
| poll_tick | input | 1 | Marks a cycle as a poll attempt |
| rx_sop | input | 1 | Beat is the first of a completion |
| rx_eop | input | 1 | Beat is the last of a completion |
| rx_beat | input | 64 | Beat payload; lower dword in [31:0] |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access ended as not-found (status or timeout) |
| rd_data | output | 32 | Aligned read data, zero on error |

## Verification
Two events can land on the same attempt, and the bench drives both cases. In the first, the start and end flags arrive on one beat. The bench sends such beats with zero and non-zero status fields and requires the beat's own status to decide the outcome, not the non-zero preset. In the second, an end-flagged beat arrives on exactly the last permitted attempt, where the timeout would otherwise fire. The bench expects a successful, aligned completion there. It contrasts this with a run where the same attempt carries no end flag and must report the error.

// File: rtl/cfgcpl_pkg.sv
package cfgcpl_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;

  localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/cpl_poll_timer.sv
module cpl_poll_timer #(
  parameter int unsigned MAX_POLLS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic attempt,
  output logic last
);
  localparam int unsigned CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (attempt && cnt_q != LAST_VAL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == LAST_VAL);

  // R11: the attempt counter never runs past the final permitted attempt
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < int'(MAX_POLLS));

endmodule

// File: rtl/cpl_beat_tracker.sv
module cpl_beat_tracker #(
  parameter int unsigned STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              attempt,
  input  logic              sop,
  input  logic [STAT_W-1:0] stat_field,
  output logic [STAT_W-1:0] status_now,
  output logic              seen
);
  localparam logic [STAT_W-1:0] STAT_PRESET = STAT_W'(1);

  logic [STAT_W-1:0] status_q;
  logic              seen_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      status_q <= STAT_PRESET;
      seen_q   <= 1'b0;
    end else if (attempt && sop) begin
      status_q <= stat_field;
      seen_q   <= 1'b1;
    end
  end

  // the start beat's own field decides a beat that also carries the end flag
  assign status_now = (attempt && sop) ? stat_field : status_q;
  assign seen       = seen_q;

  // R7: a fresh access always begins with a non-zero status and no start seen
  a_r7_preset: assert property (@(posedge clk) disable iff (rst)
    clear |=> (status_q != '0 && !seen_q));

  // R5: status only moves on a start-flagged attempt
  a_r5_status_hold: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(attempt && sop)) |=> $stable(status_q));

endmodule

// File: rtl/cpl_lane_align.sv
module cpl_lane_align
  import cfgcpl_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    size,
  input  logic [1:0]    offset,
  input  logic [DW-1:0] payload,
  output logic [DW-1:0] aligned
);
  logic [DW-1:0] byte_shift;
  logic [DW-1:0] half_shift;

  assign byte_shift = payload >> {offset, 3'b000};
  assign half_shift = payload >> {offset[1], 4'b0000};

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: aligned = {{(DW-LANE_BITS){1'b0}}, byte_shift[LANE_BITS-1:0]};
      SZ_HALF: aligned = {{(DW-2*LANE_BITS){1'b0}}, half_shift[2*LANE_BITS-1:0]};
      default: aligned = payload;
    endcase
  end

endmodule

// File: rtl/cfg_cpl_rx.sv
module cfg_cpl_rx
  import cfgcpl_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned MAX_POLLS = 500,
  parameter int unsigned STAT_LSB  = 13,
  parameter int unsigned STAT_W    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      acc_size,
  input  logic [1:0]      acc_offset,
  input  logic            poll_tick,
  input  logic            rx_sop,
  input  logic            rx_eop,
  input  logic [2*DW-1:0] rx_beat,
  output logic            done,
  output logic            err,
  output logic [DW-1:0]   rd_data
);
  localparam int unsigned STAT_POS = DW + STAT_LSB;

  logic              busy_q;
  logic [1:0]        size_q;
  logic [1:0]        off_q;
  logic              accept;
  logic              attempt;
  logic              last_try;
  logic              fin_eop;
  logic              fin_tmo;
  logic [STAT_W-1:0] status_now;
  logic              sop_seen;
  logic [DW-1:0]     aligned;

  assign accept  = start && !busy_q;
  assign attempt = busy_q && poll_tick;
  assign fin_eop = attempt && rx_eop;
  assign fin_tmo = attempt && !rx_eop && last_try;

  cpl_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .attempt (attempt),
    .last    (last_try)
  );

  cpl_beat_tracker #(.STAT_W(STAT_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept),
    .attempt    (attempt),
    .sop        (rx_sop),
    .stat_field (rx_beat[STAT_POS +: STAT_W]),
    .status_now (status_now),
    .seen       (sop_seen)
  );

  cpl_lane_align #(.DW(DW)) u_align (
    .size    (size_q),
    .offset  (off_q),
    .payload (rx_beat[DW-1:0]),
    .aligned (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      size_q  <= 2'b00;
      off_q   <= 2'b00;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        size_q <= acc_size;
        off_q  <= acc_offset;
      end
      if (fin_eop || fin_tmo) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
        if (fin_eop && status_now == '0) begin
          err     <= 1'b0;
          rd_data <= aligned;
        end else begin
          err     <= 1'b1;
          rd_data <= '0;
        end
      end
    end
  end

  // R12: completion pulse lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: a completion only follows a busy cycle
  a_r2_done_needs_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy_q));

  // R6: an error completion never carries data
  a_r6_err_no_data: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rd_data == '0));

  // R9: a single-byte read fills only the lowest lane
  a_r9_byte_width: assert property (@(posedge clk) disable iff (rst)
    (done && !err && acc_size_e'(size_q) == SZ_BYTE) |-> (rd_data[DW-1:LANE_BITS] == '0));

  // R3: a start during an access leaves the latched size alone
  a_r3_busy_start: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(size_q) && $stable(off_q));

  // R7: a successful completion needs a start-flagged beat in the packet
  a_r7_success_needs_sop: assert property (@(posedge clk) disable iff (rst)
    (fin_eop && status_now == '0) |-> (sop_seen || rx_sop));

endmodule

// File: tb/test_cfg_cpl_rx.sv
module test_cfg_cpl_rx;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 500;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  acc_size;
  logic [1:0]  acc_offset;
  logic        poll_tick;
  logic        rx_sop;
  logic        rx_eop;
  logic [63:0] rx_beat;
  logic        done;
  logic        err;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_cpl_rx i_cfg_cpl_rx (
    .clk(clk), .rst(rst), .start(start), .acc_size(acc_size),
    .acc_offset(acc_offset), .poll_tick(poll_tick), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_beat(rx_beat), .done(done), .err(err),
    .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_align(input logic [1:0] sz,
                                            input logic [1:0] off,
                                            input logic [31:0] d);
    case (sz)
      2'b00:   return (d >> (int'(off) * 8)) & 32'h0000_00FF;
      2'b01:   return (d >> (int'(off[1]) * 16)) & 32'h0000_FFFF;
      default: return d;
    endcase
  endfunction

  function automatic logic [63:0] mk_beat(input logic [2:0] st,
                                          input logic [31:0] lo);
    logic [31:0] hi;
    hi = $urandom;
    hi[15:13] = st;
    return {hi, lo};
  endfunction

  task automatic cyc(input logic t, input logic s, input logic e,
                     input logic [63:0] b);
    poll_tick = t; rx_sop = s; rx_eop = e; rx_beat = b;
    @(negedge clk);
  endtask

  task automatic begin_acc(input logic [1:0] sz, input logic [1:0] off);
    start = 1'b1; acc_size = sz; acc_offset = off;
    poll_tick = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    @(negedge clk);
    start = 1'b0; acc_size = $urandom; acc_offset = $urandom;
  endtask

  task automatic check_done(input string req, input logic exp_err,
                            input logic [31:0] exp_data);
    chk(done === 1'b1, {req, " done"}, 32'(done), 32'd1);
    chk(err === exp_err, {req, " err"}, 32'(err), 32'(exp_err));
    chk(rd_data === exp_data, {req, " data"}, rd_data, exp_data);
    cyc(1'b0, 1'b0, 1'b0, 64'd0);
    chk(done === 1'b0, "R12 done one cycle", 32'(done), 32'd0);
  endtask

  // random packet: pre-beats without flags, start beat, middle beats, gaps
  task automatic run_pkt(input logic [1:0] sz, input logic [1:0] off,
                         input logic [2:0] st, input logic [31:0] d,
                         input int npre, input int nmid, input bit single);
    bit early;
    early = 1'b0;
    begin_acc(sz, off);
    for (int i = 0; i < npre; i++) begin
      cyc(1'b1, 1'b0, 1'b0, mk_beat(3'($urandom_range(7, 1)), $urandom));
      if (done) early = 1'b1;
      cyc(1'b0, 1'b1, 1'b1, mk_beat(3'd0, $urandom));
      if (done) early = 1'b1;
    end
    if (single) begin
      cyc(1'b1, 1'b1, 1'b1, mk_beat(st, d));
    end else begin
      cyc(1'b1, 1'b1, 1'b0, mk_beat(st, $urandom));
      if (done) early = 1'b1;
      for (int i = 0; i < nmid; i++) begin
        cyc(1'b1, 1'b0, 1'b0, mk_beat(3'($urandom_range(7, 1)), $urandom));
        if (done) early = 1'b1;
      end
      cyc(1'b1, 1'b0, 1'b1, mk_beat(3'($urandom), d));
    end
    chk(!early, "R4 no early done", 32'(early), 32'd0);
    check_done("R5 R6 R8 random", st != 3'd0,
               (st != 3'd0) ? 32'd0 : exp_align(sz, off, d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1234_5EED));
    rst = 1'b1; start = 1'b0; acc_size = 2'b00; acc_offset = 2'b00;
    poll_tick = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_beat = 64'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R1 reset done", 32'(done), 32'd0);
    chk(err === 1'b0, "R1 reset err", 32'(err), 32'd0);
    chk(rd_data === 32'd0, "R1 reset data", rd_data, 32'd0);

    // R2: idle ignores beats
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b1, 1'b1, mk_beat(3'd0, 32'hDEAD_BEEF));
      chk(done === 1'b0, "R2 idle no done", 32'(done), 32'd0);
    end
    chk(rd_data === 32'd0, "R2 idle data kept", rd_data, 32'd0);

    // R8 R9 R10: every size and offset, fixed payload
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        begin_acc(2'(s), 2'(o));
        cyc(1'b1, 1'b1, 1'b0, mk_beat(3'd0, 32'h0));
        cyc(1'b1, 1'b0, 1'b1, mk_beat(3'd5, 32'hA1B2_C3D4));
        check_done("R9 R10 R8 lanes", 1'b0, exp_align(2'(s), 2'(o), 32'hA1B2_C3D4));
      end
    end

    // R2: result held through idle traffic
    held = rd_data;
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1, mk_beat(3'd0, 32'h1111_2222));
    chk(rd_data === held, "R2 idle data held", rd_data, held);

    // R7: end flag without start flag
    begin_acc(2'b10, 2'b00);
    cyc(1'b1, 1'b0, 1'b1, mk_beat(3'd0, 32'h5555_AAAA));
    check_done("R7 eop only", 1'b1, 32'd0);

    // R7: both flags on one beat, zero and non-zero status
    begin_acc(2'b10, 2'b00);
    cyc(1'b1, 1'b1, 1'b1, mk_beat(3'd0, 32'h0BAD_F00D));
    check_done("R7 single beat ok", 1'b0, 32'h0BAD_F00D);
    begin_acc(2'b10, 2'b00);
    cyc(1'b1, 1'b1, 1'b1, mk_beat(3'd4, 32'h0BAD_F00D));
    check_done("R6 single beat status", 1'b1, 32'd0);

    // R5: status from start beat, end beat status ignored
    begin_acc(2'b10, 2'b00);
    cyc(1'b1, 1'b1, 1'b0, mk_beat(3'd2, 32'h0));
    cyc(1'b1, 1'b0, 1'b1, mk_beat(3'd0, 32'h1234_5678));
    check_done("R5 status from sop", 1'b1, 32'd0);

    // R3: start during access ignored
    begin_acc(2'b00, 2'b11);
    start = 1'b1; acc_size = 2'b10; acc_offset = 2'b00;
    cyc(1'b1, 1'b1, 1'b0, mk_beat(3'd0, 32'h0));
    start = 1'b0;
    cyc(1'b1, 1'b0, 1'b1, mk_beat(3'd0, 32'hC0DE_1234));
    check_done("R3 busy start ignored", 1'b0, 32'h0000_00C0);
    cyc(1'b1, 1'b1, 1'b1, mk_beat(3'd0, 32'h0));
    chk(done === 1'b0, "R3 no restart", 32'(done), 32'd0);

    // R11: timeout on the last attempt
    begin_acc(2'b10, 2'b00);
    for (int i = 0; i < MAXP - 1; i++) cyc(1'b1, 1'b0, 1'b0, mk_beat(3'd0, 32'h0));
    chk(done === 1'b0, "R11 not before last", 32'(done), 32'd0);
    cyc(1'b1, 1'b0, 1'b0, mk_beat(3'd0, 32'h0));
    check_done("R11 timeout", 1'b1, 32'd0);

    // R11: end flag on the last attempt wins
    begin_acc(2'b01, 2'b10);
    for (int i = 0; i < MAXP - 1; i++) cyc(1'b1, 1'b0, 1'b0, mk_beat(3'd0, 32'h0));
    cyc(1'b1, 1'b1, 1'b1, mk_beat(3'd0, 32'h9876_5432));
    check_done("R11 eop on last", 1'b0, 32'h0000_9876);

    // R4: only ticked cycles count, untick end flags ignored
    begin
      bit bad;
      bad = 1'b0;
      begin_acc(2'b10, 2'b00);
      for (int i = 0; i < MAXP; i++) begin
        cyc(1'b0, 1'b1, 1'b1, mk_beat(3'd0, 32'h7));
        if (done) bad = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, mk_beat(3'd0, 32'h0));
        if ((i < MAXP - 1) && done) bad = 1'b1;
      end
      chk(!bad, "R4 untick ignored", 32'(bad), 32'd0);
      check_done("R4 timeout by ticks", 1'b1, 32'd0);
    end

    // random packets
    for (int n = 0; n < 40; n++) begin
      logic [2:0] st;
      st = ($urandom_range(3, 0) == 0) ? 3'($urandom_range(7, 1)) : 3'd0;
      run_pkt(2'($urandom), 2'($urandom), st, $urandom,
              $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(1, 0) == 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule